// File: doc/BRIEF.md
# Calibration Sequence Timer

This block turns calibration commands, delivered as control-register writes, into a timed busy window and a phase code for the analog trimming engine. It supports four calibration kinds: full, gain-plus-offset, offset only and gain only. Each kind runs in one of two modes. In self mode, busy stays high through every phase of the command without a break. In system mode, a full or gain-plus-offset command stops after its gain phase. Busy then drops, and the block waits for a second trigger before it runs the offset phase. That trigger is either a register write carrying the start-conversion bit or a strobe on the external start input.

A write strobe marks the completion of a register write, which is the moment chip select is released. The phase code tells the engine which error is being trimmed in each cycle. A one-cycle done pulse marks the end of the whole sequence. Each phase length is a parameter. A full calibration lasts DAC_CYC + GAIN_CYC + OFF_CYC cycles and a gain-plus-offset calibration lasts GAIN_CYC + OFF_CYC cycles. Offset-only lasts OFF_CYC cycles and gain-only lasts GAIN_CYC cycles.

Top module: `cal_sequencer`

## Requirements
- R1: A sequence starts only on a cycle with wr_stb=1 and wr_cal=1 while busy is low. Busy is high from the next cycle on. A write with wr_cal=0 and no pending offset phase leaves busy low.
- R2: Type codes are 0=full, 1=gain-plus-offset, 2=offset only, 3=gain only. Phase codes are 0=none, 1=DAC, 2=gain, 3=offset. A self full calibration holds busy high for DAC_CYC cycles with phase 1, then GAIN_CYC cycles with phase 2, then OFF_CYC cycles with phase 3.
- R3: A self gain-plus-offset calibration holds busy high for GAIN_CYC cycles with phase 2, then OFF_CYC cycles with phase 3, with no gap between them.
- R4: An offset-only command holds busy high for exactly OFF_CYC cycles with phase 3. A gain-only command holds busy high for exactly GAIN_CYC cycles with phase 2. Both behave the same way in self and in system mode.
- R5: A system full calibration (wr_sys=1, type 0) runs DAC_CYC cycles of phase 1 and GAIN_CYC cycles of phase 2. Busy then drops, phase reads 0, and no done pulse is given.
- R6: While waiting for the offset phase, either wr_stb with wr_conv=1 and wr_cal=0, or ext_start=1, raises busy on the next cycle. The offset phase then runs for OFF_CYC cycles with phase 3.
- R7: A system gain-plus-offset calibration (wr_sys=1, type 1) runs GAIN_CYC cycles of phase 2 and then waits for the second trigger, as in R5.
- R8: While busy is high, register writes and ext_start have no effect on busy, phase or timing.
- R9: A calibration command (wr_cal=1) that arrives during the wait discards the pending offset phase and starts the new command. A later trigger then starts nothing.
- R10: done is high for exactly one cycle: the first cycle in which busy is low after the final phase of a sequence. It stays low when busy drops for the wait.
- R11: After reset, busy, phase and done are 0. While no offset phase is pending, ext_start and start-conversion writes start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe: a control-register write has completed |
| wr_cal | input | 1 | Start-calibration bit of the written word |
| wr_conv | input | 1 | Start-conversion bit of the written word |
| wr_sys | input | 1 | 1 selects system calibration, 0 selects self calibration |
| wr_type | input | 2 | Calibration kind (0 full, 1 gain+offset, 2 offset, 3 gain) |
| ext_start | input | 1 | External start strobe, used as the second trigger |
| busy | output | 1 | High while a calibration phase is running |
| phase | output | 2 | Error being trimmed (0 none, 1 DAC, 2 gain, 3 offset) |
| done | output | 1 | One-cycle pulse when the full sequence has finished |

## Verification
The hardest state to reach from the ports is the pause inside a system calibration, where busy is low but an offset phase is still pending. Only that state makes a trigger meaningful and a new command an abort. The bench sweeps both modes across all four types. It releases each pause alternately with ext_start and with a start-conversion write. It also starts a fresh command during a pause and then checks that a later trigger starts nothing. On the first cycle of every phase the bench drives a write and an external strobe together, to show that inputs which arrive during busy leave the timing unchanged.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DAC  = 2'd1,
    PH_GAIN = 2'd2,
    PH_OFF  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    CT_FULL     = 2'd0,
    CT_GAIN_OFF = 2'd1,
    CT_OFF      = 2'd2,
    CT_GAIN     = 2'd3
  } ctype_e;

  // which phases a command runs, and whether it halts before the offset phase
  typedef struct packed {
    logic dac;
    logic gain;
    logic off;
    logic pause;
  } plan_t;
endpackage

// File: rtl/cal_plan_decode.sv
module cal_plan_decode
  import cal_pkg::*;
(
  input  logic [1:0] cal_type,
  input  logic       sys_mode,
  output plan_t      plan
);
  always_comb begin
    plan = '0;
    unique case (ctype_e'(cal_type))
      CT_FULL:     plan = '{dac: 1'b1, gain: 1'b1, off: 1'b1, pause: sys_mode};
      CT_GAIN_OFF: plan = '{dac: 1'b0, gain: 1'b1, off: 1'b1, pause: sys_mode};
      CT_OFF:      plan = '{dac: 1'b0, gain: 1'b0, off: 1'b1, pause: 1'b0};
      CT_GAIN:     plan = '{dac: 1'b0, gain: 1'b1, off: 1'b0, pause: 1'b0};
      default:     plan = '0;
    endcase
  end
endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_pkg::*;
#(
  parameter int DAC_CYC  = 97240,
  parameter int GAIN_CYC = 13880,
  parameter int OFF_CYC  = 13880
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       wr_cal,
  input  logic       wr_conv,
  input  logic       wr_sys,
  input  logic [1:0] wr_type,
  input  logic       ext_start,
  output logic       busy,
  output logic [1:0] phase,
  output logic       done
);
  localparam int MAXLEN = (DAC_CYC > GAIN_CYC) ?
                          ((DAC_CYC > OFF_CYC) ? DAC_CYC : OFF_CYC) :
                          ((GAIN_CYC > OFF_CYC) ? GAIN_CYC : OFF_CYC);
  localparam int CW = $clog2(MAXLEN + 1);

  phase_e       phase_q, phase_d;
  plan_t        plan_q, plan_d, dec_plan;
  logic         wait_q, wait_d;
  logic         done_q, done_d;
  logic         load, tmr_last;
  logic [CW-1:0] load_val;
  logic         start_cmd, trig;

  cal_plan_decode u_dec (
    .cal_type (wr_type),
    .sys_mode (wr_sys),
    .plan     (dec_plan)
  );

  cal_phase_timer #(.W(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (tmr_last)
  );

  function automatic phase_e first_phase(input plan_t p);
    if (p.dac)       return PH_DAC;
    else if (p.gain) return PH_GAIN;
    else             return PH_OFF;
  endfunction

  function automatic logic [CW-1:0] phase_len_m1(input phase_e ph);
    case (ph)
      PH_DAC:  return CW'(DAC_CYC - 1);
      PH_GAIN: return CW'(GAIN_CYC - 1);
      default: return CW'(OFF_CYC - 1);
    endcase
  endfunction

  assign start_cmd = wr_stb & wr_cal & (phase_q == PH_IDLE);
  assign trig      = wait_q & (phase_q == PH_IDLE) &
                     ((wr_stb & wr_conv & ~wr_cal) | ext_start);

  always_comb begin
    phase_d = phase_q;
    plan_d  = plan_q;
    wait_d  = wait_q;
    done_d  = 1'b0;
    load    = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start_cmd) begin
        plan_d  = dec_plan;
        phase_d = first_phase(dec_plan);
        wait_d  = 1'b0;
        load    = 1'b1;
      end else if (trig) begin
        phase_d = PH_OFF;
        wait_d  = 1'b0;
        load    = 1'b1;
      end
    end else if (tmr_last) begin
      unique case (phase_q)
        PH_DAC: begin
          phase_d = PH_GAIN;
          load    = 1'b1;
        end
        PH_GAIN: begin
          if (plan_q.off && plan_q.pause) begin
            phase_d = PH_IDLE;
            wait_d  = 1'b1;
          end else if (plan_q.off) begin
            phase_d = PH_OFF;
            load    = 1'b1;
          end else begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end
      endcase
    end
  end

  assign load_val = phase_len_m1(phase_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      plan_q  <= '0;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      plan_q  <= plan_d;
      wait_q  <= wait_d;
      done_q  <= done_d;
    end
  end

  assign busy  = (phase_q != PH_IDLE);
  assign phase = phase_q;
  assign done  = done_q;
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       wr_cal,
  input logic       wr_conv,
  input logic       ext_start,
  input logic       busy,
  input logic [1:0] phase,
  input logic       done
);
  AST_IDLE_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_stb && !wr_cal && !wr_conv && !ext_start) |=> !busy); // R1

  AST_RISE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_stb || ext_start)); // R6

  AST_DAC_ONLY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && phase == 2'd1) |-> $past(phase) == 2'd1); // R2

  AST_PAUSE_AFTER_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !done) |-> $past(phase) == 2'd2); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind cal_sequencer cal_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_stb    (wr_stb),
  .wr_cal    (wr_cal),
  .wr_conv   (wr_conv),
  .ext_start (ext_start),
  .busy      (busy),
  .phase     (phase),
  .done      (done)
);

// File: tb/tb_cal_sequencer.sv
module tb_cal_sequencer;
  localparam int DAC_CYC  = 5;
  localparam int GAIN_CYC = 3;
  localparam int OFF_CYC  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0, wr_cal = 1'b0, wr_conv = 1'b0, wr_sys = 1'b0;
  logic [1:0] wr_type = 2'd0;
  logic       ext_start = 1'b0;
  logic       busy, done;
  logic [1:0] phase;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cal_sequencer #(.DAC_CYC(DAC_CYC), .GAIN_CYC(GAIN_CYC), .OFF_CYC(OFF_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_cal(wr_cal), .wr_conv(wr_conv),
    .wr_sys(wr_sys), .wr_type(wr_type), .ext_start(ext_start),
    .busy(busy), .phase(phase), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: {busy,phase,done} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    wr_stb = 0; wr_cal = 0; wr_conv = 0; ext_start = 0;
  endtask

  // busy high with phase ph for n cycles; stray inputs on the first cycle (R8)
  task automatic seg(input logic [1:0] ph, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(busy === 1'b1 && phase === ph && done === 1'b0, req,
          {busy, phase, done}, {1'b1, ph, 1'b0});
      if (i == 0) begin
        wr_stb = 1; wr_cal = 1; wr_conv = 1; ext_start = 1; wr_type = 2'd2;
      end
      @(negedge clk);
      idle_inputs();
    end
  endtask

  task automatic finish_seq(input bit exp_done, input string req);
    chk(busy === 1'b0 && phase === 2'd0 && done === exp_done, req,
        {busy, phase, done}, {3'b000, exp_done});
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10", {busy, phase, done}, 4'b0000);
  endtask

  task automatic issue(input bit cal, input bit conv, input bit sys, input logic [1:0] typ);
    wr_stb = 1; wr_cal = cal; wr_conv = conv; wr_sys = sys; wr_type = typ;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic pulse_ext();
    ext_start = 1;
    @(negedge clk);
    ext_start = 0;
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(busy === 1'b0 && done === 1'b0, req, {busy, phase, done}, 4'b0000);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && phase === 2'd0 && done === 1'b0, "R11", {busy, phase, done}, 4'b0000);
    rst_n = 1;
    @(negedge clk);

    // R11 / R1: triggers and non-calibration writes in idle start nothing
    pulse_ext();
    quiet(2, "R11");
    issue(0, 1, 1, 2'd0);
    quiet(2, "R1");

    for (int sys = 0; sys < 2; sys++) begin
      for (int typ = 0; typ < 4; typ++) begin
        issue(1, 0, sys[0], typ[1:0]);
        case (typ)
          0: begin
            seg(2'd1, DAC_CYC, "R2");
            seg(2'd2, GAIN_CYC, sys ? "R5" : "R2");
            if (sys == 0) begin
              seg(2'd3, OFF_CYC, "R2");
              finish_seq(1, "R10");
            end
          end
          1: begin
            seg(2'd2, GAIN_CYC, sys ? "R7" : "R3");
            if (sys == 0) begin
              seg(2'd3, OFF_CYC, "R3");
              finish_seq(1, "R10");
            end
          end
          2: begin
            seg(2'd3, OFF_CYC, "R4");
            finish_seq(1, "R4");
          end
          default: begin
            seg(2'd2, GAIN_CYC, "R4");
            finish_seq(1, "R4");
          end
        endcase
        if (sys == 1 && typ < 2) begin
          finish_seq(0, "R5");
          quiet(3, "R5");
          if (typ == 0) pulse_ext();
          else          issue(0, 1, 1, 2'd3);
          seg(2'd3, OFF_CYC, "R6");
          finish_seq(1, "R10");
          quiet(2, "R11");
        end
      end
    end

    // R9: new command during the wait replaces the pending offset phase
    issue(1, 0, 1, 2'd1);
    seg(2'd2, GAIN_CYC, "R7");
    finish_seq(0, "R7");
    issue(1, 0, 0, 2'd3);
    seg(2'd2, GAIN_CYC, "R9");
    finish_seq(1, "R9");
    pulse_ext();
    quiet(3, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule